// File: doc/BRIEF.md
# DTMF Period-Counting Tone Decoder

This block turns two hard-limited comparator bits into a DTMF digit. One bit carries the band-split low-group tone and the other the high-group tone. Each bit passes through a synchroniser. The block then counts reference-clock cycles between consecutive rising edges and adds up eight consecutive periods into one block total. That total is compared against the eight-period count expected for each of the four frequencies in the group.

A group counts as matched while its most recent block total fell inside the tolerance window of one grid frequency. When both groups are matched at the same time, the early-steering flag is raised and the 4-bit code of the row/column pair is presented. The match is cleared at once in two cases: a later block falls outside every window, or a group stops producing rising edges. Either one takes the flag down.

Both outputs are plain level signals with no handshake. There is no back-pressure: a consumer qualifies `digit_o` with `early_valid_o` in any cycle it chooses. Guard timing and latching of the digit are left to the consumer.

Top module: `dtmf_period_decoder`

## Requirements
- R1: During reset, and after reset while both inputs are idle, `early_valid_o` is 0 and `digit_o` is 4'b0000.
- R2: Rows 697/770/852 Hz combined with columns 1209/1336/1477 Hz give codes 1 to 9, in the order row-major from (697,1209)=1 to (852,1477)=9.
- R3: Row 941 Hz with columns 1209/1336/1477 Hz gives 4'b1010, 4'b1011 and 4'b1100.
- R4: Column 1633 Hz with rows 697/770/852/941 Hz gives 4'b1101, 4'b1110, 4'b1111 and 4'b0000.
- R5: A tone within ±1.5 % of its grid frequency is accepted. Acceptance uses a window of ±TOL_BP/10000 (default 2.5 %) around the rounded eight-period count `round(8*CLK_HZ/f)`.
- R6: A tone more than 3.5 % from every grid frequency in its group is rejected, so `early_valid_o` stays 0.
- R7: With only one group present, `early_valid_o` stays 0. Whenever `early_valid_o` is 0, `digit_o` is 4'b0000.
- R8: A frequency lying between grid values, more than 3.5 % from each of them, gives no valid pair.
- R9: A group with no rising edge for TIMEOUT = round(2*CLK_HZ/f_slowest) cycles is lost. Here f_slowest is 697 Hz for the low group and 1209 Hz for the high group. `early_valid_o` falls within TIMEOUT+8 cycles of that group's last rising edge.
- R10: Once both tones start from idle, `early_valid_o` rises with the correct code within ten periods of the low tone. It stays high while both tones continue, and it returns once a lost group resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| lo_tone_i | input | 1 | Limited low-group tone, asynchronous |
| hi_tone_i | input | 1 | Limited high-group tone, asynchronous |
| digit_o | output | 4 | Decoded digit code, 0 when not valid |
| early_valid_o | output | 1 | Early-steering flag: valid tone pair present |

## Verification
A rising input edge reaches the period meter three cycles later. A completed block changes the group match one cycle after that, and the outputs follow one cycle later again. A digit is therefore due about eight low-tone periods plus five cycles after the tones start. The bench waits ten low-tone periods (plus margin) before sampling, and it inserts silence longer than either TIMEOUT between vectors so each vector starts from the idle state. Loss checks sample TIMEOUT+12 cycles after the tone stops. All samples are taken on the falling clock edge.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;
  localparam int GRID_N = 4;

  // Grid frequency in Hz for group (0 low, 1 high) and index 0..3.
  function automatic int unsigned grid_hz(input bit hi_grp, input int idx);
    int unsigned f;
    if (!hi_grp) begin
      case (idx)
        0:       f = 697;
        1:       f = 770;
        2:       f = 852;
        default: f = 941;
      endcase
    end else begin
      case (idx)
        0:       f = 1209;
        1:       f = 1336;
        2:       f = 1477;
        default: f = 1633;
      endcase
    end
    return f;
  endfunction

  // Rounded clock count over nper periods of tone hz.
  function automatic int unsigned block_count(input int unsigned clk_hz,
                                              input int unsigned hz,
                                              input int unsigned nper);
    return (nper * clk_hz + hz / 2) / hz;
  endfunction

  // Row/column to 4-bit code; the 1633 Hz column wraps D to zero.
  function automatic logic [3:0] digit_code(input logic [1:0] row, input logic [1:0] col);
    logic [3:0] c;
    if (col == 2'd3)      c = 4'd13 + {2'b00, row};
    else if (row == 2'd3) c = 4'd10 + {2'b00, col};
    else                  c = 4'd1 + ({2'b00, row} * 4'd3) + {2'b00, col};
    return c;
  endfunction
endpackage

// File: rtl/dtmf_edge_sync.sv
module dtmf_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign edge_o = sync_q[STAGES-1] & ~last_q;

  // Rising-edge strobe lasts one cycle only.
  p_edge_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o);
endmodule

// File: rtl/dtmf_period_meter.sv
module dtmf_period_meter #(
  parameter int unsigned TIMEOUT = 574,
  parameter int          NPER    = 8,
  parameter int          SUM_W   = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_i,
  output logic [SUM_W-1:0] sum_o,
  output logic             done_o,
  output logic             lost_o
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam int NPW   = (NPER > 1) ? $clog2(NPER) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [SUM_W-1:0] acc_q, sum_q, period;
  logic [NPW-1:0]   nper_q;
  logic             armed_q, done_q;

  assign period = SUM_W'(cnt_q) + SUM_W'(1);
  assign lost_o = armed_q && !edge_i && (cnt_q == CNT_W'(TIMEOUT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      sum_q   <= '0;
      nper_q  <= '0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (edge_i) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
        if (armed_q) begin
          if (nper_q == NPW'(NPER - 1)) begin
            sum_q  <= acc_q + period;
            done_q <= 1'b1;
            acc_q  <= '0;
            nper_q <= '0;
          end else begin
            acc_q  <= acc_q + period;
            nper_q <= nper_q + 1'b1;
          end
        end
      end else if (armed_q) begin
        if (lost_o) begin
          armed_q <= 1'b0;
          cnt_q   <= '0;
          acc_q   <= '0;
          nper_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign sum_o  = sum_q;
  assign done_o = done_q;

  // Period counter never runs past the loss limit.
  p_count_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(TIMEOUT));
endmodule

// File: rtl/dtmf_tone_match.sv
module dtmf_tone_match #(
  parameter int unsigned CLK_HZ = 3579545,
  parameter bit          HI_GRP = 1'b0,
  parameter int          NPER   = 8,
  parameter int unsigned TOL_BP = 250,
  parameter int          SUM_W  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUM_W-1:0] sum_i,
  output logic             hit_o,
  output logic [1:0]       idx_o
);
  logic [dtmf_pkg::GRID_N-1:0] hit;

  generate
    for (genvar g = 0; g < dtmf_pkg::GRID_N; g++) begin : g_win
      localparam int unsigned NOM  = dtmf_pkg::block_count(CLK_HZ, dtmf_pkg::grid_hz(HI_GRP, g), NPER);
      localparam int unsigned TOL  = (NOM * TOL_BP) / 10000;
      localparam int unsigned LO_B = NOM - TOL;
      localparam int unsigned HI_B = NOM + TOL;
      assign hit[g] = (sum_i >= SUM_W'(LO_B)) && (sum_i <= SUM_W'(HI_B));
    end
  endgenerate

  always_comb begin
    idx_o = 2'd0;
    for (int g = 0; g < dtmf_pkg::GRID_N; g++) begin
      if (hit[g]) idx_o = 2'(g);
    end
  end

  assign hit_o = |hit;

  // Tolerance windows of one group never overlap.
  p_single_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: rtl/dtmf_tone_group.sv
module dtmf_tone_group #(
  parameter int unsigned CLK_HZ      = 3579545,
  parameter bit          HI_GRP      = 1'b0,
  parameter int          NPER        = 8,
  parameter int unsigned TOL_BP      = 250,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tone_i,
  output logic       match_o,
  output logic [1:0] idx_o
);
  localparam int unsigned SLOW_HZ = dtmf_pkg::grid_hz(HI_GRP, 0);
  localparam int unsigned TIMEOUT = (2 * CLK_HZ + SLOW_HZ / 2) / SLOW_HZ;
  localparam int          CNT_W   = $clog2(TIMEOUT + 1);
  localparam int          SUM_W   = CNT_W + 1 + $clog2(NPER);

  logic             edge_s, done_s, lost_s, hit_s;
  logic [SUM_W-1:0] sum_s;
  logic [1:0]       idx_s;
  logic             match_q;
  logic [1:0]       idx_q;

  dtmf_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .din_i(tone_i), .edge_o(edge_s));

  dtmf_period_meter #(.TIMEOUT(TIMEOUT), .NPER(NPER), .SUM_W(SUM_W)) i_meter (
    .clk(clk), .rst_n(rst_n), .edge_i(edge_s),
    .sum_o(sum_s), .done_o(done_s), .lost_o(lost_s));

  dtmf_tone_match #(.CLK_HZ(CLK_HZ), .HI_GRP(HI_GRP), .NPER(NPER),
                    .TOL_BP(TOL_BP), .SUM_W(SUM_W)) i_match (
    .clk(clk), .rst_n(rst_n), .sum_i(sum_s), .hit_o(hit_s), .idx_o(idx_s));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      idx_q   <= 2'd0;
    end else if (lost_s) begin
      match_q <= 1'b0;
    end else if (done_s) begin
      match_q <= hit_s;
      idx_q   <= idx_s;
    end
  end

  assign match_o = match_q;
  assign idx_o   = idx_q;

  // A match only appears after a finished eight-period block.
  p_rise_after_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_q) |-> $past(done_s));
  // Losing the edges clears the match on the next cycle.
  p_loss_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lost_s |=> !match_q);
endmodule

// File: rtl/dtmf_period_decoder.sv
module dtmf_period_decoder #(
  parameter int unsigned CLK_HZ      = 3579545,
  parameter int          NPER        = 8,
  parameter int unsigned TOL_BP      = 250,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lo_tone_i,
  input  logic       hi_tone_i,
  output logic [3:0] digit_o,
  output logic       early_valid_o
);
  logic [1:0] tone_in;
  logic [1:0] grp_match;
  logic [1:0] grp_idx [2];
  logic       valid_q;
  logic [3:0] digit_q;

  assign tone_in = {hi_tone_i, lo_tone_i};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_grp
      dtmf_tone_group #(.CLK_HZ(CLK_HZ), .HI_GRP(g == 1), .NPER(NPER),
                        .TOL_BP(TOL_BP), .SYNC_STAGES(SYNC_STAGES)) i_group (
        .clk(clk), .rst_n(rst_n), .tone_i(tone_in[g]),
        .match_o(grp_match[g]), .idx_o(grp_idx[g]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      digit_q <= 4'd0;
    end else begin
      valid_q <= &grp_match;
      digit_q <= (&grp_match) ? dtmf_pkg::digit_code(grp_idx[0], grp_idx[1]) : 4'd0;
    end
  end

  assign early_valid_o = valid_q;
  assign digit_o       = digit_q;

  // The flag is only raised after both groups matched together.
  p_valid_needs_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    early_valid_o |-> $past(grp_match[0] && grp_match[1]));
endmodule

// File: tb/test_dtmf_period_decoder.sv
module test_dtmf_period_decoder;
  localparam int          CLK_PERIOD = 10;
  localparam int unsigned BENCH_HZ   = 200000;
  localparam longint      MOD        = longint'(BENCH_HZ) * 10;
  localparam int unsigned TO_LO      = (2 * BENCH_HZ + 348) / 697;
  localparam int unsigned TO_HI      = (2 * BENCH_HZ + 604) / 1209;
  localparam int          NVEC       = 25;
  // lo tone (0.1 Hz), hi tone (0.1 Hz), expected valid, expected code, requirement
  localparam int unsigned VEC [NVEC][5] = '{
    '{6970, 12090, 1,  1, 2}, '{6970, 13360, 1,  2, 2}, '{6970, 14770, 1,  3, 2},
    '{7700, 12090, 1,  4, 2}, '{7700, 13360, 1,  5, 2}, '{7700, 14770, 1,  6, 2},
    '{8520, 12090, 1,  7, 2}, '{8520, 13360, 1,  8, 2}, '{8520, 14770, 1,  9, 2},
    '{9410, 12090, 1, 10, 3}, '{9410, 13360, 1, 11, 3}, '{9410, 14770, 1, 12, 3},
    '{6970, 16330, 1, 13, 4}, '{7700, 16330, 1, 14, 4}, '{8520, 16330, 1, 15, 4},
    '{9410, 16330, 1,  0, 4},
    '{7792, 13200, 1,  5, 5}, '{9297, 16526, 1,  0, 5},
    '{7700, 13894, 0,  0, 6}, '{8179, 12090, 0,  0, 6},
    '{7700,     0, 0,  0, 7}, '{   0, 14770, 0,  0, 7},
    '{6970, 11000, 0,  0, 8}, '{8000, 13360, 0,  0, 8},
    '{8520, 13360, 1,  8, 10}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lo_tone = 1'b0;
  logic       hi_tone = 1'b0;
  logic [3:0] digit;
  logic       early_valid;
  int unsigned lo_dhz = 0, hi_dhz = 0;
  longint     lo_ph = 0, hi_ph = 0;
  int         checks = 0, failures = 0, cycles = 0;
  bit         done = 1'b0;

  dtmf_period_decoder #(.CLK_HZ(BENCH_HZ)) i_dtmf_period_decoder (
    .clk(clk), .rst_n(rst_n), .lo_tone_i(lo_tone), .hi_tone_i(hi_tone),
    .digit_o(digit), .early_valid_o(early_valid));

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Phase-accumulator tone sources, updated away from the active edge.
  always @(negedge clk) begin
    if (lo_dhz == 0) begin lo_ph = 0; lo_tone = 1'b0; end
    else begin
      lo_ph = lo_ph + lo_dhz;
      if (lo_ph >= MOD) lo_ph = lo_ph - MOD;
      lo_tone = (lo_ph < MOD / 2);
    end
    if (hi_dhz == 0) begin hi_ph = 0; hi_tone = 1'b0; end
    else begin
      hi_ph = hi_ph + hi_dhz;
      if (hi_ph >= MOD) hi_ph = hi_ph - MOD;
      hi_tone = (hi_ph < MOD / 2);
    end
  end

  function automatic string tag_of(input int unsigned n);
    case (n)
      2:       return "R2";
      3:       return "R3";
      4:       return "R4";
      5:       return "R5";
      6:       return "R6";
      7:       return "R7";
      8:       return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic exp_v, input logic [3:0] exp_d);
    checks++;
    if (early_valid !== exp_v || digit !== exp_d) begin
      failures++;
      $display("FAIL %s actual valid=%0b digit=%0d expected valid=%0b digit=%0d",
               tag, early_valid, digit, exp_v, exp_d);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Watchdog: a hung run is one failed check.
  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000) begin
      checks++;
      failures++;
      $display("FAIL R10 watchdog actual cycles=%0d expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    // R1: reset state, during and after reset
    wait_cycles(4);
    check("R1", 1'b0, 4'd0);
    rst_n = 1'b1;
    wait_cycles(50);
    check("R1", 1'b0, 4'd0);

    // Table walk: silence, then both tones, then sample after ten low periods
    for (int i = 0; i < NVEC; i++) begin
      int unsigned ref_dhz;
      lo_dhz = 0;
      hi_dhz = 0;
      wait_cycles(700);
      lo_dhz  = VEC[i][0];
      hi_dhz  = VEC[i][1];
      ref_dhz = (VEC[i][0] != 0) ? VEC[i][0] : VEC[i][1];
      wait_cycles(int'((10 * MOD) / ref_dhz) + 20);
      check(tag_of(VEC[i][4]), VEC[i][2] != 0, 4'(VEC[i][3]));
    end

    // R10: digit 8 stays valid over a further block
    wait_cycles(int'((8 * MOD) / 8520) + 20);
    check("R10", 1'b1, 4'd8);

    // R9: high group stops, flag falls within its timeout
    hi_dhz = 0;
    wait_cycles(int'(TO_HI) + 12);
    check("R9", 1'b0, 4'd0);

    // R10: high group resumes, pair is valid again
    hi_dhz = 13360;
    wait_cycles(int'((10 * MOD) / 13360) + 20);
    check("R10", 1'b1, 4'd8);

    // R9: low group stops
    lo_dhz = 0;
    wait_cycles(int'(TO_LO) + 12);
    check("R9", 1'b0, 4'd0);

    finish_run();
  end
endmodule